// File: doc/BRIEF.md
# Two-Cycle Word-Addressed Integer Core

This block is a small, non-pipelined 32-bit integer processor. It runs programs from a single internal word-addressed memory. That memory holds both the instructions and the data, and it is filled through a boot write port while the core is held in reset. After reset is released, the core repeats a fixed two-step sequence for every instruction. In the first cycle it fetches the word at the program counter into an instruction register. In the second cycle it decodes that word as a register, immediate or jump format and executes it. Executing covers writing a register, storing to memory and choosing the next program counter.

The core has one finite-state machine with three states. `ST_FETCH` always moves to `ST_EXEC`, which is the fetch transition. `ST_EXEC` moves back to `ST_FETCH` for any ordinary instruction, which is the retire transition. `ST_EXEC` moves to `ST_STOP` on a halt instruction or an undecodable word, which is the stop transition. `ST_STOP` holds until reset.

The outside world sees three things. It sees the halted and illegal flags. It sees a one-cycle debug strobe that carries a register value. It sees a count of retired instructions. The program counter counts in words. Sequential flow, branch offsets, jump offsets and the link value all work on PC+1.

Top module: `mcc_core`

## Requirements
- R1: Instruction layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. The immediate is [15:0] and the jump offset is [25:0]. Opcode 0x00 is register format. Its funct selects add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, sll 0x04, srl 0x06, sra 0x07, seq 0x28, sne 0x29, slt 0x2a or sle 0x2c. The result is written to rd.
- R2: Immediate opcodes write rt: addi 0x08, subi 0x0a, andi 0x0c, ori 0x0d, xori 0x0e. The 16-bit immediate is sign-extended for every use. lhi 0x0f writes the raw immediate into bits [31:16] and zeros into bits [15:0].
- R3: The compare operations write 1 when the relation holds and 0 otherwise. The register forms are seq, sne, slt and sle. The immediate forms are seqi 0x18, snei 0x19, slti 0x1a and slei 0x1c. The less-than and less-or-equal relations compare signed values.
- R4: Shifts use only the low 3 bits of the amount. The register forms take the amount from the value of rt. The immediate forms take it from the immediate: slli 0x14, srli 0x16, srai 0x17. srl and srli fill with zeros, and sra and srai fill with copies of the sign bit.
- R5: lw 0x23 loads rt from memory and sw 0x2b stores rt to memory. The word address is rs plus the sign-extended immediate, reduced to the memory's address width.
- R6: beqz 0x04 tests whether rs is zero and bnez 0x05 tests whether rs is nonzero. When the test holds, the next PC is PC+1 plus the sign-extended immediate. Otherwise the next PC is PC+1.
- R7: j 0x02 and jal 0x03 set the next PC to PC+1 plus the sign-extended 26-bit offset. jr 0x12 and jalr 0x13 set the next PC to the value of rs. jal and jalr write PC+1 into register 31.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: Opcode 0x30 retires, sets `halted`, and stops all later execution until reset.
- R10: Opcode 0x31 raises `dbg_valid` for exactly one cycle, with `dbg_value` equal to the value of rs.
- R11: An undefined opcode, or an undefined funct under opcode 0x00, sets both `illegal` and `halted`. That word makes no register or memory update and is not counted as retired.
- R12: Every instruction takes exactly two clock cycles. `retired` increases by one at the end of each completed instruction. In reset, `halted`, `illegal`, `dbg_valid` and `retired` are all 0.
- R13: The boot port writes memory only while `rst_n` is low. Boot writes presented while the core runs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; boot loading happens while it is low |
| boot_we | input | 1 | Boot write enable |
| boot_addr | input | AW | Boot word address |
| boot_data | input | 32 | Boot write data |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an undecodable word |
| dbg_valid | output | 1 | One-cycle debug print strobe |
| dbg_value | output | 32 | Register value that goes with the strobe |
| retired | output | CNT_W | Count of completed instructions |

## Verification
The hardest results to see from the ports are the ones that leave no direct trace. A skipped instruction, a discarded write to register 0 and a return address are all of this kind. The bench therefore builds programs in which every such effect turns into a later debug print. Forward and backward branches and jumps step over print instructions that must never fire. A subroutine reached by both jal and jalr prints its link register before returning. Random register-format and immediate-format operations take full 32-bit operands that are first loaded from memory. Equal operand pairs are forced now and then so that the equality compares produce a result of 1.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_STOP} state_t;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRL,
        OP_SRA, OP_SEQ, OP_SNE, OP_SLT, OP_SLE, OP_HIGH
    } alu_op_t;

    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_t;

    typedef struct packed {
        alu_op_t alu;
        logic    imm_b;
        logic    wr;
        dst_t    dsel;
        logic    ld;
        logic    st;
        logic    bz;
        logic    bnz;
        logic    jmp;
        logic    jreg;
        logic    link;
        logic    stop;
        logic    show;
        logic    bad;
    } ctl_t;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_J     = 6'h02;
    localparam logic [5:0] OPC_JAL   = 6'h03;
    localparam logic [5:0] OPC_BEQZ  = 6'h04;
    localparam logic [5:0] OPC_BNEZ  = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SUBI  = 6'h0a;
    localparam logic [5:0] OPC_ANDI  = 6'h0c;
    localparam logic [5:0] OPC_ORI   = 6'h0d;
    localparam logic [5:0] OPC_XORI  = 6'h0e;
    localparam logic [5:0] OPC_LHI   = 6'h0f;
    localparam logic [5:0] OPC_JR    = 6'h12;
    localparam logic [5:0] OPC_JALR  = 6'h13;
    localparam logic [5:0] OPC_SLLI  = 6'h14;
    localparam logic [5:0] OPC_SRLI  = 6'h16;
    localparam logic [5:0] OPC_SRAI  = 6'h17;
    localparam logic [5:0] OPC_SEQI  = 6'h18;
    localparam logic [5:0] OPC_SNEI  = 6'h19;
    localparam logic [5:0] OPC_SLTI  = 6'h1a;
    localparam logic [5:0] OPC_SLEI  = 6'h1c;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2b;
    localparam logic [5:0] OPC_HALT  = 6'h30;
    localparam logic [5:0] OPC_PRINT = 6'h31;

    localparam logic [5:0] FN_SLL = 6'h04;
    localparam logic [5:0] FN_SRL = 6'h06;
    localparam logic [5:0] FN_SRA = 6'h07;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SEQ = 6'h28;
    localparam logic [5:0] FN_SNE = 6'h29;
    localparam logic [5:0] FN_SLT = 6'h2a;
    localparam logic [5:0] FN_SLE = 6'h2c;

endpackage

// File: rtl/mcc_mem.sv
module mcc_mem #(
    parameter int WORDS = 256,
    parameter int XLEN  = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [AW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RW-1:0]   raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [RW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);
    always_comb begin
        ctl       = '0;
        ctl.alu   = OP_ADD;
        ctl.dsel  = DST_RT;
        ctl.imm_b = 1'b1;
        ctl.wr    = 1'b1;
        case (opcode)
            OPC_REG: begin
                ctl.dsel  = DST_RD;
                ctl.imm_b = 1'b0;
                case (funct)
                    FN_ADD:  ctl.alu = OP_ADD;
                    FN_SUB:  ctl.alu = OP_SUB;
                    FN_AND:  ctl.alu = OP_AND;
                    FN_OR:   ctl.alu = OP_OR;
                    FN_XOR:  ctl.alu = OP_XOR;
                    FN_SLL:  ctl.alu = OP_SLL;
                    FN_SRL:  ctl.alu = OP_SRL;
                    FN_SRA:  ctl.alu = OP_SRA;
                    FN_SEQ:  ctl.alu = OP_SEQ;
                    FN_SNE:  ctl.alu = OP_SNE;
                    FN_SLT:  ctl.alu = OP_SLT;
                    FN_SLE:  ctl.alu = OP_SLE;
                    default: begin ctl.bad = 1'b1; ctl.wr = 1'b0; end
                endcase
            end
            OPC_ADDI: ctl.alu = OP_ADD;
            OPC_SUBI: ctl.alu = OP_SUB;
            OPC_ANDI: ctl.alu = OP_AND;
            OPC_ORI:  ctl.alu = OP_OR;
            OPC_XORI: ctl.alu = OP_XOR;
            OPC_LHI:  ctl.alu = OP_HIGH;
            OPC_SLLI: ctl.alu = OP_SLL;
            OPC_SRLI: ctl.alu = OP_SRL;
            OPC_SRAI: ctl.alu = OP_SRA;
            OPC_SEQI: ctl.alu = OP_SEQ;
            OPC_SNEI: ctl.alu = OP_SNE;
            OPC_SLTI: ctl.alu = OP_SLT;
            OPC_SLEI: ctl.alu = OP_SLE;
            OPC_LW:   ctl.ld  = 1'b1;
            OPC_SW:   begin ctl.st  = 1'b1; ctl.wr = 1'b0; end
            OPC_BEQZ: begin ctl.bz  = 1'b1; ctl.wr = 1'b0; end
            OPC_BNEZ: begin ctl.bnz = 1'b1; ctl.wr = 1'b0; end
            OPC_J:    begin ctl.jmp = 1'b1; ctl.wr = 1'b0; end
            OPC_JAL:  begin ctl.jmp = 1'b1; ctl.link = 1'b1; ctl.dsel = DST_LINK; end
            OPC_JR:   begin ctl.jreg = 1'b1; ctl.wr = 1'b0; end
            OPC_JALR: begin ctl.jreg = 1'b1; ctl.link = 1'b1; ctl.dsel = DST_LINK; end
            OPC_HALT: begin ctl.stop = 1'b1; ctl.wr = 1'b0; end
            OPC_PRINT: begin ctl.show = 1'b1; ctl.wr = 1'b0; end
            default:  begin ctl.bad = 1'b1; ctl.wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
    import mcc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int SH_W  = 3
) (
    input  alu_op_t         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int HALF = XLEN / 2;
    logic [SH_W-1:0] amt;
    assign amt = b[SH_W-1:0];

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << amt;
            OP_SRL:  y = a >> amt;
            OP_SRA:  y = XLEN'($signed(a) >>> amt);
            OP_SEQ:  y = XLEN'(a == b);
            OP_SNE:  y = XLEN'(a != b);
            OP_SLT:  y = XLEN'($signed(a) <  $signed(b));
            OP_SLE:  y = XLEN'($signed(a) <= $signed(b));
            OP_HIGH: y = {b[HALF-1:0], {HALF{1'b0}}};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mcc_core.sv
module mcc_core
    import mcc_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int CNT_W     = 32,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_we,
    input  logic [AW-1:0]    boot_addr,
    input  logic [31:0]      boot_data,
    output logic             halted,
    output logic             illegal,
    output logic             dbg_valid,
    output logic [31:0]      dbg_value,
    output logic [CNT_W-1:0] retired
);
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RW     = $clog2(NREG);
    localparam logic [RW-1:0] LINK_REG = RW'(NREG - 1);

    state_t            state;
    logic [XLEN-1:0]   pc;
    logic [XLEN-1:0]   ir;
    logic [XLEN-1:0]   fetch_word;
    logic [XLEN-1:0]   load_word;
    ctl_t              ctl;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   imm_sx;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   pc_inc;
    logic [XLEN-1:0]   pc_next;
    logic [XLEN-1:0]   wb_data;
    logic [RW-1:0]     wb_addr;
    logic              in_exec;
    logic              rf_we;
    logic              taken;
    logic [AW-1:0]     data_addr;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [XLEN-1:0]   mem_wdata;

    assign in_exec   = (state == ST_EXEC);
    assign imm_sx    = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign pc_inc    = pc + 1'b1;
    assign data_addr = AW'(rs_val + imm_sx);

    // Boot port is live only in reset; the store path owns the port afterwards.
    assign mem_we    = rst_n ? (in_exec && ctl.st) : boot_we;
    assign mem_waddr = rst_n ? data_addr : boot_addr;
    assign mem_wdata = rst_n ? rt_val : boot_data;

    mcc_mem #(.WORDS(MEM_WORDS), .XLEN(XLEN)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (AW'(pc)),
        .rdata_a (fetch_word),
        .raddr_b (data_addr),
        .rdata_b (load_word)
    );

    mcc_decode u_dec (
        .opcode (ir[31:26]),
        .funct  (ir[5:0]),
        .ctl    (ctl)
    );

    mcc_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (ir[25:21]),
        .rdata_a (rs_val),
        .raddr_b (ir[20:16]),
        .rdata_b (rt_val)
    );

    mcc_alu #(.XLEN(XLEN), .SH_W(3)) u_alu (
        .op (ctl.alu),
        .a  (rs_val),
        .b  (ctl.imm_b ? imm_sx : rt_val),
        .y  (alu_y)
    );

    assign rf_we = in_exec && ctl.wr;

    always_comb begin
        unique case (ctl.dsel)
            DST_RD:   wb_addr = ir[15:11];
            DST_LINK: wb_addr = LINK_REG;
            default:  wb_addr = ir[20:16];
        endcase
        if (ctl.ld)        wb_data = load_word;
        else if (ctl.link) wb_data = pc_inc;
        else               wb_data = alu_y;
    end

    assign taken = (ctl.bz && rs_val == '0) || (ctl.bnz && rs_val != '0);

    always_comb begin
        if (ctl.jreg)     pc_next = rs_val;
        else if (ctl.jmp) pc_next = pc_inc + {{(XLEN-26){ir[25]}}, ir[25:0]};
        else if (taken)   pc_next = pc_inc + imm_sx;
        else              pc_next = pc_inc;
    end

    // State register, program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= fetch_word;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ctl.bad || ctl.stop) begin
                        state <= ST_STOP;
                    end else begin
                        pc    <= pc_next;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted    <= 1'b0;
            illegal   <= 1'b0;
            dbg_valid <= 1'b0;
            dbg_value <= '0;
            retired   <= '0;
        end else begin
            dbg_valid <= 1'b0;
            if (in_exec) begin
                if (ctl.bad) begin
                    illegal <= 1'b1;
                    halted  <= 1'b1;
                end else begin
                    retired <= retired + 1'b1;
                    if (ctl.stop) halted <= 1'b1;
                    if (ctl.show) begin
                        dbg_valid <= 1'b1;
                        dbg_value <= rs_val;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mcc_checks.sv
module mcc_checks #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halted,
    input logic             illegal,
    input logic             dbg_valid,
    input logic [CNT_W-1:0] retired
);
    AST_RETIRE_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (retired != $past(retired)) |-> (retired == $past(retired) + 1'b1)); // R12
    AST_RETIRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (retired != $past(retired)) |=> $stable(retired)); // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(retired)); // R9
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !dbg_valid); // R9
    AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted); // R11
    AST_PRINT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |=> !dbg_valid); // R10
endmodule

bind mcc_core mcc_checks #(.CNT_W(CNT_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .illegal   (illegal),
    .dbg_valid (dbg_valid),
    .retired   (retired)
);

// File: tb/tb_mcc_core.sv
module tb_mcc_core;
    localparam int WORDS = 256;
    localparam int AW    = 8;
    localparam int CW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_we = 1'b0;
    logic [AW-1:0] boot_addr = '0;
    logic [31:0]   boot_data = '0;
    logic          halted, illegal, dbg_valid;
    logic [31:0]   dbg_value;
    logic [CW-1:0] retired;

    logic [31:0] prog [WORDS];
    logic [31:0] expq [128];
    logic [31:0] cap  [128];
    int exp_n = 0;
    int cap_n = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    mcc_core #(.MEM_WORDS(WORDS), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .boot_we(boot_we), .boot_addr(boot_addr),
        .boot_data(boot_data), .halted(halted), .illegal(illegal),
        .dbg_valid(dbg_valid), .dbg_value(dbg_value), .retired(retired)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && dbg_valid && cap_n < 128) begin
            cap[cap_n] = dbg_value;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] s, logic [4:0] t, logic [4:0] d);
        return {6'h00, s, t, d, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] s, logic [4:0] t, logic [15:0] imm);
        return {op, s, t, imm};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] off);
        return {op, off};
    endfunction

    function automatic logic [31:0] ref_r(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            6'h20: return a + b;
            6'h22: return a - b;
            6'h24: return a & b;
            6'h25: return a | b;
            6'h26: return a ^ b;
            6'h04: return a << b[2:0];
            6'h06: return a >> b[2:0];
            6'h07: return 32'($signed(a) >>> b[2:0]);
            6'h28: return (a == b) ? 32'd1 : 32'd0;
            6'h29: return (a != b) ? 32'd1 : 32'd0;
            6'h2a: return ($signed(a) <  $signed(b)) ? 32'd1 : 32'd0;
            6'h2c: return ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    function automatic logic [31:0] ref_i(logic [5:0] op, logic [31:0] a, logic [15:0] imm);
        logic [31:0] s;
        s = {{16{imm[15]}}, imm};
        case (op)
            6'h08: return ref_r(6'h20, a, s);
            6'h0a: return ref_r(6'h22, a, s);
            6'h0c: return ref_r(6'h24, a, s);
            6'h0d: return ref_r(6'h25, a, s);
            6'h0e: return ref_r(6'h26, a, s);
            6'h0f: return {imm, 16'h0000};
            6'h14: return ref_r(6'h04, a, s);
            6'h16: return ref_r(6'h06, a, s);
            6'h17: return ref_r(6'h07, a, s);
            6'h18: return ref_r(6'h28, a, s);
            6'h19: return ref_r(6'h29, a, s);
            6'h1a: return ref_r(6'h2a, a, s);
            6'h1c: return ref_r(6'h2c, a, s);
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    function automatic logic [5:0] pick_fn(int k);
        case (k)
            0: return 6'h20;  1: return 6'h22;  2: return 6'h24;  3: return 6'h25;
            4: return 6'h26;  5: return 6'h04;  6: return 6'h06;  7: return 6'h07;
            8: return 6'h28;  9: return 6'h29; 10: return 6'h2a; default: return 6'h2c;
        endcase
    endfunction

    function automatic logic [5:0] pick_op(int k);
        case (k)
            0: return 6'h08;  1: return 6'h0a;  2: return 6'h0c;  3: return 6'h0d;
            4: return 6'h0e;  5: return 6'h0f;  6: return 6'h14;  7: return 6'h16;
            8: return 6'h17;  9: return 6'h18; 10: return 6'h19; 11: return 6'h1a;
            default: return 6'h1c;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < WORDS; i++) prog[i] = 32'h0000_0000;
        exp_n = 0;
    endtask

    task automatic boot_and_start();
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            boot_we = 1'b1; boot_addr = AW'(i); boot_data = prog[i];
        end
        @(negedge clk);
        boot_we = 1'b0;
        check("R12 reset halted", 32'(halted), 32'd0);
        check("R12 reset illegal", 32'(illegal), 32'd0);
        check("R12 reset dbg_valid", 32'(dbg_valid), 32'd0);
        check("R12 reset retired", retired, 32'd0);
        cap_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(string req, int lim);
        int n = 0;
        while (!halted && n < lim) begin
            @(negedge clk);
            n++;
        end
        check({req, " reached halt"}, 32'(halted), 32'd1);
    endtask

    task automatic cmp_prints(string req);
        check({req, " print count"}, 32'(cap_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(req, cap[i], expq[i]);
        end
    endtask

    task automatic push(logic [31:0] v);
        expq[exp_n] = v;
        exp_n = exp_n + 1;
    endtask

    // Watchdog
    initial begin
        #800000;
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // Run A: random register and immediate operations (R1..R4, R8)
        clear_prog();
        for (int t = 0; t < 24; t++) begin
            logic [31:0] a, b, e;
            logic [4:0]  d;
            a = $urandom();
            b = $urandom();
            if ($urandom() % 4 == 0) b = a;
            d = 5'($urandom() % 32);
            prog[200 + 2*t] = a;
            prog[201 + 2*t] = b;
            prog[4*t]     = enc_i(6'h23, 5'd0, 5'd1, 16'(200 + 2*t));
            prog[4*t + 1] = enc_i(6'h23, 5'd0, 5'd2, 16'(201 + 2*t));
            if ($urandom() % 2 == 0) begin
                logic [5:0] fn;
                fn = pick_fn(int'($urandom() % 12));
                prog[4*t + 2] = enc_r(fn, 5'd1, 5'd2, d);
                e = ref_r(fn, a, b);
            end else begin
                logic [5:0] op;
                logic [15:0] imm;
                op = pick_op(int'($urandom() % 13));
                imm = (b == a) ? a[15:0] : b[15:0];
                if (b == a && a[15] == 1'b0) imm = 16'h8000 | a[15:0];
                prog[4*t + 2] = enc_i(op, 5'd1, d, imm);
                e = ref_i(op, a, imm);
            end
            prog[4*t + 3] = enc_i(6'h31, d, 5'd0, 16'h0);
            push((d == 5'd0) ? 32'd0 : e);
        end
        prog[96] = enc_i(6'h30, 5'd0, 5'd0, 16'h0);
        boot_and_start();
        wait_halt("R9 run A", 2000);
        cmp_prints("R1 R2 R3 R4 R8 random op");
        check("R12 run A retired", retired, 32'd97);

        // Run B: directed corners
        clear_prog();
        prog[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'hFFFB);
        prog[1]  = enc_i(6'h31, 5'd1, 5'd0, 16'h0);   push(32'hFFFF_FFFB); // R2
        prog[2]  = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
        prog[3]  = enc_i(6'h31, 5'd0, 5'd0, 16'h0);   push(32'h0);         // R8
        prog[4]  = enc_i(6'h0f, 5'd0, 5'd2, 16'h8001);
        prog[5]  = enc_i(6'h31, 5'd2, 5'd0, 16'h0);   push(32'h8001_0000); // R2
        prog[6]  = enc_i(6'h17, 5'd2, 5'd3, 16'd9);
        prog[7]  = enc_i(6'h31, 5'd3, 5'd0, 16'h0);   push(32'hC000_8000); // R4
        prog[8]  = enc_i(6'h16, 5'd2, 5'd4, 16'd12);
        prog[9]  = enc_i(6'h31, 5'd4, 5'd0, 16'h0);   push(32'h0800_1000); // R4
        prog[10] = enc_i(6'h2b, 5'd0, 5'd1, 16'd100);
        prog[11] = enc_i(6'h08, 5'd0, 5'd5, 16'd110);
        prog[12] = enc_i(6'h23, 5'd5, 5'd6, 16'hFFF6);
        prog[13] = enc_i(6'h31, 5'd6, 5'd0, 16'h0);   push(32'hFFFF_FFFB); // R5
        prog[14] = enc_i(6'h04, 5'd0, 5'd0, 16'd2);
        prog[15] = enc_i(6'h31, 5'd1, 5'd0, 16'h0);
        prog[16] = enc_i(6'h31, 5'd1, 5'd0, 16'h0);
        prog[17] = enc_i(6'h05, 5'd0, 5'd0, 16'd5);
        prog[18] = enc_i(6'h05, 5'd1, 5'd0, 16'd1);
        prog[19] = enc_i(6'h31, 5'd1, 5'd0, 16'h0);
        prog[20] = enc_j(6'h03, 26'd3);
        prog[21] = enc_j(6'h02, 26'd5);
        prog[24] = enc_i(6'h31, 5'd31, 5'd0, 16'h0);  push(32'd21);        // R7
        prog[25] = enc_i(6'h12, 5'd31, 5'd0, 16'h0);
        prog[27] = enc_i(6'h08, 5'd0, 5'd7, 16'd31);
        prog[28] = enc_i(6'h13, 5'd7, 5'd0, 16'h0);
        prog[29] = enc_i(6'h31, 5'd31, 5'd0, 16'h0);
        prog[30] = enc_i(6'h30, 5'd0, 5'd0, 16'h0);
        prog[31] = enc_i(6'h31, 5'd31, 5'd0, 16'h0);  push(32'd29);        // R7
        prog[32] = enc_i(6'h12, 5'd31, 5'd0, 16'h0);  push(32'd29);
        boot_and_start();
        // R13: boot writes attempted while running must be ignored
        boot_we = 1'b1; boot_addr = 8'd30; boot_data = enc_i(6'h31, 5'd1, 5'd0, 16'h0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R12 two cycles each, after 6 edges", retired, 32'd3);
        @(posedge clk);
        @(negedge clk);
        check("R12 mid-instruction count", retired, 32'd3);
        wait_halt("R9 run B", 500);
        boot_we = 1'b0;
        cmp_prints("R6 R7 R13 directed");
        check("R6 R7 run B retired", retired, 32'd27);
        check("R9 run B not illegal", 32'(illegal), 32'd0);
        repeat (10) @(negedge clk);
        check("R9 retired frozen after halt", retired, 32'd27);
        check("R9 no prints after halt", 32'(cap_n), 32'(exp_n));

        // Run C: backward jump and illegal opcode
        clear_prog();
        prog[0] = enc_j(6'h02, 26'd3);
        prog[1] = enc_i(6'h08, 5'd0, 5'd1, 16'd9);
        prog[2] = enc_i(6'h31, 5'd1, 5'd0, 16'h0);    push(32'd9);
        prog[3] = enc_i(6'h3F, 5'd1, 5'd1, 16'h0);
        prog[4] = enc_j(6'h02, 26'h3FF_FFFC);
        prog[5] = enc_i(6'h31, 5'd1, 5'd0, 16'h0);
        boot_and_start();
        wait_halt("R11 run C", 200);
        cmp_prints("R7 R11 backward jump");
        check("R11 illegal opcode flag", 32'(illegal), 32'd1);
        check("R11 illegal not retired", retired, 32'd4);

        // Run D: undefined funct
        clear_prog();
        prog[0] = enc_r(6'h3E, 5'd0, 5'd0, 5'd3);
        prog[1] = enc_i(6'h31, 5'd0, 5'd0, 16'h0);
        boot_and_start();
        wait_halt("R11 run D", 100);
        check("R11 illegal funct flag", 32'(illegal), 32'd1);
        check("R11 illegal funct retired", retired, 32'd0);
        check("R11 illegal funct no print", 32'(cap_n), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule